// File: doc/BRIEF.md
# Rectangle Blit Engine with Raster Operations

This block copies a rectangle of bytes inside a byte-addressed frame buffer. For every destination byte it combines a source byte, a pattern byte and the current destination byte through an 8-bit three-input raster operation (ROP), then writes the result back. Software first sets the source and pattern start addresses, the rectangle size, a line pitch for each map, a vertical wrap code for the source, two ROP codes and the mix controls. It then starts the engine by handing over the destination start address on a separate start path.

An optional mix map holds one bit per processed byte. That bit picks the ROP applied to the byte: the foreground code or the background code. The source map can repeat vertically every 2^n lines. This lets a short source tile fill a tall rectangle. Each of the source and pattern start addresses can also be taken from the point where the previous operation ended. All memory traffic goes through one request/response port, and only one access is outstanding at a time.

Top module: `blit_engine`

## Requirements
- R1: After reset `busy`, `done` and `mem_req_valid` are low and `cur_dst` is 0.
- R2: Configuration is written with `cfg_we` high and is selected by `cfg_sel`, as follows. 0 = source start. 1 = pattern start. 2 = X count. 3 = Y count. 4 = source pitch. 5 = pattern pitch. 6 = destination pitch. 7 = wrap code, 3 bits. 8 = foreground ROP. 9 = background ROP. 10 = reload bits: bit 0 is source, bit 1 is pattern. 11 = mix enable, bit 0. 12 = mix map base. A `start_valid` pulse while idle loads `start_addr` as the destination start and starts the operation. In the next cycle `busy` is high and `cur_dst` equals `start_addr`.
- R3: Each byte is handled in a fixed order. First comes a mix-map read, only when mix is enabled. Then a source read, a pattern read, a destination read and a destination write, so each byte costs 5 or 4 accepted requests. A request holds its address and direction until `mem_req_ready`. Every request, writes included, gets exactly one `mem_rsp_valid`.
- R4: The rectangle spans X count + 1 bytes per line and Y count + 1 lines. Within a line every map address steps by 1. Each map's next line starts at that map's previous line start plus its own pitch.
- R5: The ROP result bit i equals bit (4·pattern[i] + 2·source[i] + destination[i]) of the selected 8-bit ROP code.
- R6: With mix enabled, byte k is the k-th byte in processing order, counted from 0. It uses bit k mod 8 of the byte at mix base + k/8. A 1 selects the foreground ROP and a 0 selects the background ROP. With mix disabled, every byte uses the foreground ROP.
- R7: Wrap code c in 0..6 makes the source go back to its operation start address after every 2^c lines. Code 7 disables wrapping.
- R8: When a reload bit is set, that map starts from the address the previous operation ended at. This is the start of the line after its last line, with wrap applied. The end address is 0 after reset. When the bit is clear, the programmed start is used.
- R9: `busy` stays high until the response to the final destination write arrives. `done` pulses for one cycle, in the same cycle that `busy` falls.
- R10: While `busy` is high, configuration writes and `start_valid` are ignored.
- R11: After completion, `cur_dst` holds the destination start of the line after the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration field select |
| cfg_wdata | input | 22 | Configuration write value |
| start_valid | input | 1 | Start request |
| start_addr | input | 22 | Destination start address for the start request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_dst | output | 22 | Internal destination address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 22 | Request byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Response valid (read data or write acknowledge) |
| mem_rsp_data | input | 8 | Read data |

## Verification
A wrong line counter or pitch add shows up as a wrongly placed byte in frame memory. It is visible as soon as the next line's first destination write is issued, and `cur_dst` shows it at completion. A broken wrap counter sends the first source read of the line after the wrap to the wrong address. A mix-index or ROP-select fault corrupts the very byte it applies to. A stale end address only shows up in the following reload operation, so the bench chains operations. A stuck phase or pending flag shows as a wrong request count or a `busy` that never falls.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int unsigned ADDR_W  = 22;
    localparam int unsigned CNT_W   = 12;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ROP_W   = 8;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned WRAP_W  = 3;
    localparam int unsigned LANE_W  = $clog2(DATA_W);
    localparam int unsigned IDX_W   = 2 * CNT_W;
    localparam logic [WRAP_W-1:0] WRAP_NEVER = '1;

    typedef enum logic [SEL_W-1:0] {
        SEL_SRC     = 4'd0,
        SEL_PAT     = 4'd1,
        SEL_XCNT    = 4'd2,
        SEL_YCNT    = 4'd3,
        SEL_SPITCH  = 4'd4,
        SEL_PPITCH  = 4'd5,
        SEL_DPITCH  = 4'd6,
        SEL_WRAP    = 4'd7,
        SEL_FG      = 4'd8,
        SEL_BG      = 4'd9,
        SEL_RELOAD  = 4'd10,
        SEL_MIXEN   = 4'd11,
        SEL_MIXBASE = 4'd12
    } sel_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_MIX, PH_SRC, PH_PAT, PH_DRD, PH_DWR
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0]  xcnt;
        logic [CNT_W-1:0]  ycnt;
        logic [CNT_W-1:0]  spitch;
        logic [CNT_W-1:0]  ppitch;
        logic [CNT_W-1:0]  dpitch;
        logic [WRAP_W-1:0] wrap;
        logic [ROP_W-1:0]  fg;
        logic [ROP_W-1:0]  bg;
        logic              mix_en;
        logic [ADDR_W-1:0] mix_base;
    } walk_cfg_t;

    typedef struct packed {
        walk_cfg_t         walk;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] pat;
        logic [1:0]        reload;
    } cfg_regs_t;
endpackage

// File: rtl/blit_cfg_regs.sv
module blit_cfg_regs
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              start_valid,
    input  logic              busy,
    input  logic [ADDR_W-1:0] end_src,
    input  logic [ADDR_W-1:0] end_pat,
    output walk_cfg_t         walk,
    output logic              go,
    output logic [ADDR_W-1:0] op_src,
    output logic [ADDR_W-1:0] op_pat
);
    cfg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we && !busy) begin
            case (cfg_sel)
                SEL_SRC:     regs_d.src          = cfg_wdata;
                SEL_PAT:     regs_d.pat          = cfg_wdata;
                SEL_XCNT:    regs_d.walk.xcnt    = cfg_wdata[CNT_W-1:0];
                SEL_YCNT:    regs_d.walk.ycnt    = cfg_wdata[CNT_W-1:0];
                SEL_SPITCH:  regs_d.walk.spitch  = cfg_wdata[CNT_W-1:0];
                SEL_PPITCH:  regs_d.walk.ppitch  = cfg_wdata[CNT_W-1:0];
                SEL_DPITCH:  regs_d.walk.dpitch  = cfg_wdata[CNT_W-1:0];
                SEL_WRAP:    regs_d.walk.wrap    = cfg_wdata[WRAP_W-1:0];
                SEL_FG:      regs_d.walk.fg      = cfg_wdata[ROP_W-1:0];
                SEL_BG:      regs_d.walk.bg      = cfg_wdata[ROP_W-1:0];
                SEL_RELOAD:  regs_d.reload       = cfg_wdata[1:0];
                SEL_MIXEN:   regs_d.walk.mix_en  = cfg_wdata[0];
                SEL_MIXBASE: regs_d.walk.mix_base = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q           <= '0;
            regs_q.walk.wrap <= WRAP_NEVER;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign walk   = regs_q.walk;
    assign go     = start_valid && !busy;
    assign op_src = regs_q.reload[0] ? end_src : regs_q.src;
    assign op_pat = regs_q.reload[1] ? end_pat : regs_q.pat;
endmodule

// File: rtl/blit_rop_unit.sv
module blit_rop_unit
    import blit_pkg::*;
(
    input  logic [ROP_W-1:0]  rop,
    input  logic [DATA_W-1:0] pat,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    output logic [DATA_W-1:0] res
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign res[i] = rop[{pat[i], src[i], dst[i]}];
    end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  walk_cfg_t         cfg,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] op_src,
    input  logic [ADDR_W-1:0] op_pat,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic [DATA_W-1:0] rop_res,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [ROP_W-1:0]  rop_code,
    output logic [DATA_W-1:0] rop_src,
    output logic [DATA_W-1:0] rop_pat,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [ADDR_W-1:0] end_src,
    output logic [ADDR_W-1:0] end_pat
);
    typedef struct packed {
        phase_e            phase;
        logic              pend;
        logic [CNT_W-1:0]  x;
        logic [CNT_W-1:0]  y;
        logic [CNT_W-1:0]  wcnt;
        logic [IDX_W-1:0]  k;
        logic [ADDR_W-1:0] sbase;
        logic [ADDR_W-1:0] sline;
        logic [ADDR_W-1:0] saddr;
        logic [ADDR_W-1:0] pline;
        logic [ADDR_W-1:0] paddr;
        logic [ADDR_W-1:0] dline;
        logic [ADDR_W-1:0] daddr;
        logic [ADDR_W-1:0] esrc;
        logic [ADDR_W-1:0] epat;
        logic [DATA_W-1:0] sbyte;
        logic [DATA_W-1:0] pbyte;
        logic [DATA_W-1:0] wdata;
        logic              mix_bit;
        logic              done;
    } walk_t;

    walk_t             walk_d, walk_q;
    phase_e            first_ph;
    logic              wrap_hit;
    logic              last_x;
    logic              last_y;
    logic [ADDR_W-1:0] s_next;
    logic [ADDR_W-1:0] p_next;
    logic [ADDR_W-1:0] d_next;

    always_comb begin
        first_ph = cfg.mix_en ? PH_MIX : PH_SRC;
        wrap_hit = (cfg.wrap != WRAP_NEVER) &&
                   (walk_q.wcnt == ((CNT_W'(1) << cfg.wrap) - CNT_W'(1)));
        last_x   = walk_q.x == cfg.xcnt;
        last_y   = walk_q.y == cfg.ycnt;
        s_next   = wrap_hit ? walk_q.sbase : walk_q.sline + ADDR_W'(cfg.spitch);
        p_next   = walk_q.pline + ADDR_W'(cfg.ppitch);
        d_next   = walk_q.dline + ADDR_W'(cfg.dpitch);

        walk_d      = walk_q;
        walk_d.done = 1'b0;

        if (walk_q.phase == PH_IDLE) begin
            if (go) begin
                walk_d.phase = first_ph;
                walk_d.pend  = 1'b0;
                walk_d.x     = '0;
                walk_d.y     = '0;
                walk_d.wcnt  = '0;
                walk_d.k     = '0;
                walk_d.sbase = op_src;
                walk_d.sline = op_src;
                walk_d.saddr = op_src;
                walk_d.pline = op_pat;
                walk_d.paddr = op_pat;
                walk_d.dline = start_addr;
                walk_d.daddr = start_addr;
            end
        end else if (!walk_q.pend) begin
            if (mem_req_ready) walk_d.pend = 1'b1;
        end else if (mem_rsp_valid) begin
            walk_d.pend = 1'b0;
            case (walk_q.phase)
                PH_MIX: begin
                    walk_d.mix_bit = mem_rsp_data[walk_q.k[LANE_W-1:0]];
                    walk_d.phase   = PH_SRC;
                end
                PH_SRC: begin
                    walk_d.sbyte = mem_rsp_data;
                    walk_d.phase = PH_PAT;
                end
                PH_PAT: begin
                    walk_d.pbyte = mem_rsp_data;
                    walk_d.phase = PH_DRD;
                end
                PH_DRD: begin
                    walk_d.wdata = rop_res;
                    walk_d.phase = PH_DWR;
                end
                default: begin
                    walk_d.k = walk_q.k + IDX_W'(1);
                    if (!last_x) begin
                        walk_d.x     = walk_q.x + CNT_W'(1);
                        walk_d.saddr = walk_q.saddr + ADDR_W'(1);
                        walk_d.paddr = walk_q.paddr + ADDR_W'(1);
                        walk_d.daddr = walk_q.daddr + ADDR_W'(1);
                        walk_d.phase = first_ph;
                    end else begin
                        walk_d.x     = '0;
                        walk_d.y     = walk_q.y + CNT_W'(1);
                        walk_d.wcnt  = wrap_hit ? '0 : walk_q.wcnt + CNT_W'(1);
                        walk_d.sline = s_next;
                        walk_d.saddr = s_next;
                        walk_d.pline = p_next;
                        walk_d.paddr = p_next;
                        walk_d.dline = d_next;
                        walk_d.daddr = d_next;
                        if (last_y) begin
                            walk_d.phase = PH_IDLE;
                            walk_d.done  = 1'b1;
                            walk_d.esrc  = s_next;
                            walk_d.epat  = p_next;
                        end else begin
                            walk_d.phase = first_ph;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q       <= '0;
            walk_q.phase <= PH_IDLE;
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        case (walk_q.phase)
            PH_MIX:  mem_req_addr = cfg.mix_base + ADDR_W'(walk_q.k >> LANE_W);
            PH_SRC:  mem_req_addr = walk_q.saddr;
            PH_PAT:  mem_req_addr = walk_q.paddr;
            default: mem_req_addr = walk_q.daddr;
        endcase
    end

    assign mem_req_valid = (walk_q.phase != PH_IDLE) && !walk_q.pend;
    assign mem_req_write = walk_q.phase == PH_DWR;
    assign mem_req_wdata = walk_q.wdata;
    assign rop_code      = (!cfg.mix_en || walk_q.mix_bit) ? cfg.fg : cfg.bg;
    assign rop_src       = walk_q.sbyte;
    assign rop_pat       = walk_q.pbyte;
    assign busy          = walk_q.phase != PH_IDLE;
    assign done          = walk_q.done;
    assign cur_dst       = walk_q.daddr;
    assign end_src       = walk_q.esrc;
    assign end_pat       = walk_q.epat;
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cur_dst,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    walk_cfg_t         walk;
    logic              go;
    logic [ADDR_W-1:0] op_src;
    logic [ADDR_W-1:0] op_pat;
    logic [ADDR_W-1:0] end_src;
    logic [ADDR_W-1:0] end_pat;
    logic [ROP_W-1:0]  rop_code;
    logic [DATA_W-1:0] rop_src;
    logic [DATA_W-1:0] rop_pat;
    logic [DATA_W-1:0] rop_res;

    blit_cfg_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .start_valid (start_valid),
        .busy        (busy),
        .end_src     (end_src),
        .end_pat     (end_pat),
        .walk        (walk),
        .go          (go),
        .op_src      (op_src),
        .op_pat      (op_pat)
    );

    blit_walker i_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg           (walk),
        .go            (go),
        .start_addr    (start_addr),
        .op_src        (op_src),
        .op_pat        (op_pat),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rop_res       (rop_res),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .rop_code      (rop_code),
        .rop_src       (rop_src),
        .rop_pat       (rop_pat),
        .busy          (busy),
        .done          (done),
        .cur_dst       (cur_dst),
        .end_src       (end_src),
        .end_pat       (end_pat)
    );

    blit_rop_unit i_rop (
        .rop (rop_code),
        .pat (rop_pat),
        .src (rop_src),
        .dst (mem_rsp_data),
        .res (rop_res)
    );
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk
    import blit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic [ADDR_W-1:0] start_addr,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] cur_dst,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && !busy) |=> (busy && cur_dst == $past(start_addr)));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_valid) |=> $stable(cur_dst) || busy || done);
endmodule

bind blit_engine blit_engine_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_valid   (start_valid),
    .start_addr    (start_addr),
    .busy          (busy),
    .done          (done),
    .cur_dst       (cur_dst),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/test_blit_engine.sv
`timescale 1ns/1ps
module test_blit_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [21:0] cfg_wdata = '0;
    logic        start_valid = 1'b0;
    logic [21:0] start_addr = '0;
    logic        busy, done;
    logic [21:0] cur_dst;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b1;
    logic [21:0] mem_req_addr;
    logic [7:0]  mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;

    always #5 clk = ~clk;

    blit_engine i_blit_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start_valid(start_valid), .start_addr(start_addr),
        .busy(busy), .done(done), .cur_dst(cur_dst),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    logic [7:0]  mem   [4096];
    logic [7:0]  exp_m [4096];
    logic        stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          req_cnt = 0;
    int          done_cnt = 0;
    int          n_cmp = 0;
    int          n_bad = 0;

    // memory model: one-cycle response for every accepted request
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            req_cnt++;
            if (mem_req_write) mem[mem_req_addr[11:0]] <= mem_req_wdata;
            mem_rsp_data  <= mem[mem_req_addr[11:0]];
            mem_rsp_valid <= 1'b1;
        end
        lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_req_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) if (done) done_cnt++;

    // operation settings and bench-side end addresses
    int b_src, b_pat, b_xc, b_yc, b_sp, b_pp, b_dp, b_wrap, b_fg, b_bg, b_rl, b_mixen, b_mixbase, b_dst;
    int e_src = 0, e_pat = 0;
    int m_src, m_pat, m_dst, m_reqs;

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel[3:0]; cfg_wdata = val[21:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_all();
        wr(0, b_src);  wr(1, b_pat);  wr(2, b_xc);   wr(3, b_yc);
        wr(4, b_sp);   wr(5, b_pp);   wr(6, b_dp);   wr(7, b_wrap);
        wr(8, b_fg);   wr(9, b_bg);   wr(10, b_rl);  wr(11, b_mixen);
        wr(12, b_mixbase);
    endtask

    // reference model built from R4..R8 and R11
    task automatic model();
        int sb, sl, pl, dl, wc, k;
        logic [7:0] s, p, d, r, code;
        logic mb;
        for (int i = 0; i < 4096; i++) exp_m[i] = mem[i];
        sb = b_rl[0] ? e_src : b_src;
        pl = b_rl[1] ? e_pat : b_pat;
        sl = sb; dl = b_dst; wc = 0; k = 0;
        for (int y = 0; y <= b_yc; y++) begin
            for (int x = 0; x <= b_xc; x++) begin
                s = mem[(sl + x) & 4095];
                p = mem[(pl + x) & 4095];
                d = mem[(dl + x) & 4095];
                mb = b_mixen[0] ? mem[(b_mixbase + k / 8) & 4095][k % 8] : 1'b1;
                code = mb ? b_fg[7:0] : b_bg[7:0];
                for (int i = 0; i < 8; i++) r[i] = code[4 * p[i] + 2 * s[i] + d[i]];
                exp_m[(dl + x) & 4095] = r;
                k++;
            end
            if (b_wrap != 7 && wc == (1 << b_wrap) - 1) begin
                sl = sb; wc = 0;
            end else begin
                sl = sl + b_sp; wc++;
            end
            pl = pl + b_pp;
            dl = dl + b_dp;
        end
        m_src = sl; m_pat = pl; m_dst = dl;
        m_reqs = k * (b_mixen[0] ? 5 : 4);
    endtask

    task automatic wait_idle(input string req);
        int guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 20000) chk(req, "watchdog busy", 1, 0);
        @(negedge clk);
    endtask

    task automatic check_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== exp_m[i] && bad < 0) bad = i;
        if (bad >= 0) chk(req, $sformatf("mem[%0h]", bad), int'(mem[bad]), int'(exp_m[bad]));
        else chk(req, "mem", 0, 0);
    endtask

    task automatic run_op(input string req);
        int rq0, dn0;
        program_all();
        model();
        rq0 = req_cnt; dn0 = done_cnt;
        @(negedge clk);
        start_valid = 1'b1; start_addr = b_dst[21:0];
        @(negedge clk);
        start_valid = 1'b0;
        wait_idle(req);
        check_mem(req);
        chk("R9", "done pulses", done_cnt - dn0, 1);
        chk("R11", "cur_dst", int'(cur_dst), m_dst);
        chk("R3", "request count", req_cnt - rq0, m_reqs);
        e_src = m_src; e_pat = m_pat;
    endtask

    task automatic defaults();
        b_src = 'h100; b_pat = 'h300; b_dst = 'h600; b_xc = 3; b_yc = 2;
        b_sp = 16; b_pp = 20; b_dp = 24; b_wrap = 7; b_fg = 'hCC; b_bg = 'h0F;
        b_rl = 0; b_mixen = 0; b_mixbase = 'h050;
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "mem_req_valid", mem_req_valid, 0);
        chk("R1", "cur_dst", int'(cur_dst), 0);
    endtask

    task automatic t_copy();
        defaults();
        run_op("R4");                               // copy, bg ignored (R6)
        defaults(); b_xc = 0; b_yc = 0; run_op("R4");  // single byte
        defaults(); b_xc = 15; b_yc = 7; b_dst = 'h700; run_op("R4");
    endtask

    task automatic t_rops();
        defaults(); b_fg = 'h96; run_op("R5");      // p^s^d
        defaults(); b_fg = 'hF0; run_op("R5");      // pattern copy
        defaults(); b_fg = 'hE8; run_op("R5");      // majority
    endtask

    task automatic t_mix();
        defaults(); b_mixen = 1; b_fg = 'hCC; b_bg = 'hF0; b_xc = 5; b_yc = 2;
        run_op("R6");
        defaults(); b_mixen = 0; b_fg = 'hCC; b_bg = 'hF0; run_op("R6");
    endtask

    task automatic t_wrap();
        defaults(); b_wrap = 1; b_yc = 5; run_op("R7");
        chk("R7", "wrap-1 end source", e_src, 'h100);
        defaults(); b_wrap = 0; b_yc = 3; run_op("R7");
        defaults(); b_wrap = 2; b_yc = 5; run_op("R7");
        chk("R7", "wrap-2 end source", e_src, 'h120);
    endtask

    task automatic t_reload();
        defaults(); run_op("R8");
        defaults(); b_src = 'h200; b_pat = 'h3F0; b_rl = 3; run_op("R8");
        defaults(); b_src = 'h140; b_rl = 2; run_op("R8");
    endtask

    task automatic t_busy();
        int dn0;
        defaults(); b_xc = 3; b_yc = 3; b_fg = 'h66;
        program_all();
        model();
        dn0 = done_cnt;
        @(negedge clk);
        start_valid = 1'b1; start_addr = b_dst[21:0];
        @(negedge clk);
        start_valid = 1'b0;
        chk("R2", "busy after start", busy, 1);
        chk("R2", "cur_dst after start", int'(cur_dst), b_dst);
        wr(8, 'h00);                                // ignored FG write (R10)
        @(negedge clk);
        start_valid = 1'b1; start_addr = 22'h900;  // ignored start (R10)
        @(negedge clk);
        start_valid = 1'b0;
        wait_idle("R10");
        check_mem("R10");
        chk("R10", "done pulses", done_cnt - dn0, 1);
        chk("R11", "cur_dst", int'(cur_dst), m_dst);
        e_src = m_src; e_pat = m_pat;
    endtask

    task automatic t_stall();
        stall_en = 1'b1;
        defaults(); b_mixen = 1; b_fg = 'h96; b_bg = 'h3C; b_xc = 7; b_yc = 3;
        b_dp = 16; run_op("R3");
        stall_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37) ^ (i >> 5));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy();
        t_rops();
        t_mix();
        t_wrap();
        t_reload();
        t_busy();
        t_stall();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule